// File: doc/BRIEF.md
# Configurable-Register Single-Port RAM

This block is a parameterized single-port memory. One address bus serves both reads and writes, and it has a write-data input, a write enable and a read-data output. Three compile-time switches each pick a registered or a combinational path. The first covers the write word. The second covers the address and the write enable together. The third covers the read output. The input-side stages run on `inClk` and the output stage runs on `outClk`. With every switch off, neither clock is used and the memory is fully asynchronous.

The word count can be any value above half of `2**ADDR_W`. It does not have to be a power of two. Stored words start at zero and are never touched by reset. Reset clears only the pipeline stages. A read at or above the word count returns all-X.

When the address stage is registered, a write is captured on the rising edge of `inClk`. It lands in the array on the falling edge of that same clock cycle. When the address stage is combinational, the write enable acts as a level. Every location the address moves through while the enable is high gets overwritten.

Top module: `flexreg_ram`

## Requirements
- R1: Before any write, every in-range word reads as zero.
- R2: While `rstN` is low, a rising output-clock edge drives a registered read output to zero. Reset never changes a stored word.
- R3: With the address stage registered, address and write enable are sampled on the rising edge of `inClk`. The array write uses the sampled pair at the next falling edge of `inClk`. Reads also use the sampled address, so a combinational output shows a new address's word one `inClk` edge after that address is presented.
- R4: With the address stage combinational, the write enable is level-sensitive. Every in-range address presented while it is high holds the current write word afterwards.
- R5: With the data stage registered, the write word is captured on the rising edge of `inClk`. With it combinational, the word present at the moment of the array write is stored. Either way, a word held for one full cycle after the capturing edge is stored.
- R6: A registered output updates only on the rising edge of `outClk`. It shows the word at the array address one `outClk` edge later and holds its earlier value until then. A combinational output follows the word at the array address with no clock.
- R7: Left unset, each of the three stages defaults to registered, and the word count defaults to `2**ADDR_W`.
- R8: A write to an address at or above the word count changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inClk | input | 1 | Clock for the write-data and address/enable stages and the array write |
| outClk | input | 1 | Clock for the read-output stage |
| rstN | input | 1 | Active-low synchronous reset of the pipeline stages only |
| wrEn | input | 1 | Write enable |
| addr | input | ADDR_W | Shared read/write address |
| wrData | input | DATA_W | Word to store |
| rdData | output | DATA_W | Word read from the array |

## Verification
Six builds share one stimulus: all-registered by default, fully asynchronous, registered-input with combinational output, live data with registered address, a level-write variant, and default word count. Each build is read at the point its latency predicts. A read one edge early must still show the earlier word, which separates zero, one and two cycles of delay. The stimulus covers:
- full read sweeps before any write, which expose initial contents;
- distinct per-address write patterns, which expose address aliasing;
- writes above the word count, which only the default-count build may keep;
- a held-enable sweep across several addresses, which separates level writes from edge writes;
- a mid-run reset, which must clear the output stages but keep the stored words.

// File: rtl/flexreg_ram_pkg.sv
package flexreg_ram_pkg;

  // Strobes handed from the address/enable control to the datapath.
  typedef struct packed {
    logic wrEn;     // write request for the current array address
    logic inRange;  // current array address lies below the word count
  } ramStrobe_t;

endpackage

// File: rtl/flexreg_ram_ctrl.sv
module flexreg_ram_ctrl
  import flexreg_ram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_WORDS = 2 ** ADDR_W,
  parameter bit REG_ADDR  = 1'b1
) (
  input  logic              inClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ramStrobe_t        stb,
  output logic [ADDR_W-1:0] curAddr
);

  localparam logic [ADDR_W:0] WORD_LIMIT = (ADDR_W + 1)'(NUM_WORDS);

  logic liveWe;

  generate
    if (REG_ADDR) begin : g_staged
      logic              weQ;
      logic [ADDR_W-1:0] addrQ;

      always_ff @(posedge inClk) begin
        if (!rstN) weQ <= 1'b0;
        else       weQ <= wrEn;
        addrQ <= addr;
      end

      assign liveWe  = weQ;
      assign curAddr = addrQ;

      // A staged write request can only come from an enable seen one edge earlier.
      assert_we_sampled_R3 : assert property (@(posedge inClk) disable iff (!rstN)
        $rose(stb.wrEn) |-> $past(wrEn));

      // Leaving reset, no write request may be pending.
      assert_stage_clear_R2 : assert property (@(posedge inClk) disable iff (!rstN)
        $rose(rstN) |-> !stb.wrEn);
    end else begin : g_live
      assign liveWe  = wrEn;
      assign curAddr = addr;
    end
  endgenerate

  always_comb begin
    stb.wrEn    = liveWe;
    stb.inRange = ({1'b0, curAddr} < WORD_LIMIT);
  end

endmodule

// File: rtl/flexreg_ram_dp.sv
module flexreg_ram_dp
  import flexreg_ram_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int NUM_WORDS = 2 ** ADDR_W,
  parameter bit REG_WDATA = 1'b1,
  parameter bit REG_ADDR  = 1'b1,
  parameter bit REG_RDATA = 1'b1
) (
  input  logic              inClk,
  input  logic              outClk,
  input  logic              rstN,
  input  ramStrobe_t        stb,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [NUM_WORDS] = '{default: '0};
  logic [DATA_W-1:0] wrWord;
  logic [DATA_W-1:0] curWord;

  // Write-data stage.
  generate
    if (REG_WDATA) begin : g_dataReg
      logic [DATA_W-1:0] dataQ;
      always_ff @(posedge inClk) dataQ <= wrData;
      assign wrWord = dataQ;
    end else begin : g_dataLive
      assign wrWord = wrData;
    end
  endgenerate

  // Array write: edge-driven after capture, or level-driven without capture.
  generate
    if (REG_ADDR) begin : g_edgeWrite
      always_ff @(negedge inClk) begin
        if (stb.wrEn && stb.inRange) mem[curAddr] <= wrWord;
      end

      if (REG_WDATA) begin : g_landChk
        // The word staged at the last rising edge is in the array by the next one.
        assert_lands_R3 : assert property (@(posedge inClk) disable iff (!rstN)
          (stb.wrEn && stb.inRange) |-> (mem[curAddr] == wrWord));
      end
    end else begin : g_levelWrite
      always_latch begin
        if (stb.wrEn && stb.inRange) mem[curAddr] <= wrWord;
      end
    end
  endgenerate

  // Array read, unknown above the word count.
  always_comb begin
    if (stb.inRange) curWord = mem[curAddr];
    else             curWord = 'x;
  end

  // Read-output stage.
  generate
    if (REG_RDATA) begin : g_outReg
      logic [DATA_W-1:0] rdQ;
      logic              primed;

      always_ff @(posedge outClk) begin
        if (!rstN) begin
          rdQ    <= '0;
          primed <= 1'b0;
        end else begin
          rdQ    <= curWord;
          primed <= 1'b1;
        end
      end

      assign rdData = rdQ;

      // Output moves only when the sampled array word moved.
      assert_rd_stable_R6 : assert property (@(posedge outClk) disable iff (!rstN)
        (primed && $stable(curWord)) |=> $stable(rdData));

      // Leaving reset, the registered output is cleared.
      assert_out_clear_R2 : assert property (@(posedge outClk) disable iff (!rstN)
        $rose(rstN) |-> (rdData == '0));
    end else begin : g_outLive
      assign rdData = curWord;
    end
  endgenerate

endmodule

// File: rtl/flexreg_ram.sv
module flexreg_ram
  import flexreg_ram_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int NUM_WORDS = 2 ** ADDR_W,
  parameter bit REG_WDATA = 1'b1,
  parameter bit REG_ADDR  = 1'b1,
  parameter bit REG_RDATA = 1'b1
) (
  input  logic              inClk,
  input  logic              outClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  ramStrobe_t        stb;
  logic [ADDR_W-1:0] curAddr;

  flexreg_ram_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS),
    .REG_ADDR (REG_ADDR)
  ) u_ctrl (
    .inClk  (inClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .stb    (stb),
    .curAddr(curAddr)
  );

  flexreg_ram_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS),
    .REG_WDATA(REG_WDATA),
    .REG_ADDR (REG_ADDR),
    .REG_RDATA(REG_RDATA)
  ) u_dp (
    .inClk  (inClk),
    .outClk (outClk),
    .rstN   (rstN),
    .stb    (stb),
    .curAddr(curAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/flexreg_ram_bench.sv
`timescale 1ns/1ps
module flexreg_ram_bench;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] qA, qB, qC, qD, qE, qF;

  int checks = 0;
  int failures = 0;
  int lastAddr = 0;
  logic [DW-1:0] refN [16];
  logic [DW-1:0] refF [16];

  always #2.5 clk = ~clk;

  // A: stage options left at defaults (all registered).
  flexreg_ram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW)) u_flexreg_ram (
    .inClk(clk), .outClk(clk), .rstN(rstN), .wrEn(we), .addr(addr), .wrData(data), .rdData(qA));
  // B: fully asynchronous.
  flexreg_ram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .REG_WDATA(0), .REG_ADDR(0), .REG_RDATA(0)) u_flexreg_ram_b (
    .inClk(clk), .outClk(clk), .rstN(rstN), .wrEn(we), .addr(addr), .wrData(data), .rdData(qB));
  // C: registered inputs, combinational output.
  flexreg_ram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .REG_WDATA(1), .REG_ADDR(1), .REG_RDATA(0)) u_flexreg_ram_c (
    .inClk(clk), .outClk(clk), .rstN(rstN), .wrEn(we), .addr(addr), .wrData(data), .rdData(qC));
  // D: live data, registered address and output.
  flexreg_ram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .REG_WDATA(0), .REG_ADDR(1), .REG_RDATA(1)) u_flexreg_ram_d (
    .inClk(clk), .outClk(clk), .rstN(rstN), .wrEn(we), .addr(addr), .wrData(data), .rdData(qD));
  // E: registered data, level write, combinational output.
  flexreg_ram #(.DATA_W(DW), .ADDR_W(AW), .NUM_WORDS(NW), .REG_WDATA(1), .REG_ADDR(0), .REG_RDATA(0)) u_flexreg_ram_e (
    .inClk(clk), .outClk(clk), .rstN(rstN), .wrEn(we), .addr(addr), .wrData(data), .rdData(qE));
  // F: default word count and stage options.
  flexreg_ram #(.DATA_W(DW), .ADDR_W(AW)) u_flexreg_ram_f (
    .inClk(clk), .outClk(clk), .rstN(rstN), .wrEn(we), .addr(addr), .wrData(data), .rdData(qF));

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // All tasks start and end 1 ns after a rising edge.
  task automatic doWrite(input int a, input logic [DW-1:0] d);
    addr = a[AW-1:0];
    data = d;
    we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    @(posedge clk); #1;
    if (a < NW) refN[a] = d;
    refF[a] = d;
    lastAddr = a;
  endtask

  task automatic doRead(input int a, input string tag);
    bit prevOk = (lastAddr < NW);
    logic [DW-1:0] prevN = refN[lastAddr];
    logic [DW-1:0] prevF = refF[lastAddr];
    addr = a[AW-1:0];
    we = 1'b0;
    #1;
    if (a < NW) begin
      chk({tag, " R6 comb B"}, qB, refN[a]);
      chk({tag, " R6 comb E"}, qE, refN[a]);
    end
    @(posedge clk); #1;
    if (a < NW) chk({tag, " R3 addr-stage C"}, qC, refN[a]);
    if (prevOk) begin
      chk({tag, " R6 hold A"}, qA, prevN);
      chk({tag, " R6 hold D"}, qD, prevN);
    end
    chk({tag, " R6 hold F"}, qF, prevF);
    @(posedge clk); #1;
    if (a < NW) begin
      chk({tag, " R7 default A"}, qA, refN[a]);
      chk({tag, " R6 reg D"}, qD, refN[a]);
    end
    chk({tag, " R7 default-count F"}, qF, refF[a]);
    lastAddr = a;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      refN[i] = '0;
      refF[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1;
    chk("R2 reset A", qA, '0);
    chk("R2 reset D", qD, '0);
    chk("R2 reset F", qF, '0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1: untouched contents read zero.
    for (int a = 0; a < 16; a++) doRead(a, "R1");

    // R5: per-address patterns, including the range top for F.
    for (int a = 0; a < 16; a++) doWrite(a, 8'(a * 37 + 5));
    for (int a = 0; a < 16; a++) doRead(a, "R5");

    // R8: writes above the word count must not alias onto low words.
    for (int a = NW; a < 16; a++) doWrite(a, 8'(8'hC0 + a));
    for (int a = 0; a < 16; a++) doRead(a, "R8");

    // R4: enable held high while the address walks 2..5.
    data = 8'h3C;
    we = 1'b1;
    for (int a = 2; a < 6; a++) begin
      addr = a[AW-1:0];
      @(posedge clk); #1;
    end
    we = 1'b0;
    @(posedge clk); #1;
    for (int a = 2; a < 6; a++) begin
      refN[a] = 8'h3C;
      refF[a] = 8'h3C;
    end
    lastAddr = 5;
    for (int a = 0; a < NW; a++) doRead(a, "R4");

    // R2: mid-run reset clears outputs and keeps words.
    rstN = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R2 mid reset A", qA, '0);
    chk("R2 mid reset D", qD, '0);
    chk("R2 mid reset F", qF, '0);
    rstN = 1'b1;
    @(posedge clk); #1;
    for (int a = 0; a < 16; a++) doRead(a, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule